// File: doc/BRIEF.md
# Cyclic Converter Step Sequencer

This block is the digital control for a cyclic (algorithmic) analog-to-digital converter, where one track/hold, sub-ADC and residue amplifier stage is reused for every partial conversion. A start pulse launches a run of `N_STEPS` clock cycles. The first step converts the external input. Each later step converts the amplified residue that the stage fed back. In each step the sequencer takes in the sub-ADC code, returns that code as the select for the stage's DAC, and drives the mux that picks the stage input.

The sub-ADC resolves `SUB_BITS` bits per step, and each step carries `EFF_BITS` bits of weight. When `SUB_BITS` exceeds `EFF_BITS`, neighbouring codes overlap. This redundancy lets the sub-ADC make small decision errors. A shift-and-add register removes the redundancy: it shifts the running sum left by `EFF_BITS` and adds the new code, so carries fall out of the overlapping bits. When the codes do not overlap, the register only concatenates them. After the last step, the block publishes the corrected word together with a one-cycle done pulse.

Top module: `cyc_adc_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy, done and in_sel are 0, and dac_sel and dout are all zeros.
- R2: If soc is high at a rising edge while busy is low, busy is high from the next cycle on. Busy stays high for exactly N_STEPS cycles. Done goes high in the cycle after the N_STEPS-th following edge.
- R3: During the first step in_sel is 0, which selects the external input. During each later step in_sel is 1, which selects the residue. Outside a conversion in_sel is 0.
- R4: In every cycle that follows a busy cycle, dac_sel equals the sub_code value that was present during that busy cycle.
- R5: dout equals the sum over steps k = 0..N_STEPS-1 of code_k × 2^(EFF_BITS × (N_STEPS-1-k)). Step 0 is the most significant, and carries from overlapping bits propagate in full.
- R6: soc is ignored while busy is high. The timing of the running conversion and its dout are unchanged, and no new conversion starts once done arrives.
- R7: done is high for exactly one cycle per conversion, and busy is low in that cycle.
- R8: dout changes only in a cycle where done is high, and otherwise holds its last value.
- R9: The parameters must satisfy 1 ≤ SUB_BITS ≤ 6, 1 ≤ EFF_BITS ≤ SUB_BITS and N_STEPS ≥ 2. Any other setting is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| soc | input | 1 | Start of conversion, sampled while idle |
| sub_code | input | SUB_BITS | Sub-ADC decision for the current step |
| in_sel | output | 1 | Stage input mux: 0 selects the external input, 1 selects the residue |
| dac_sel | output | SUB_BITS | DAC select, the most recently captured code |
| busy | output | 1 | A conversion is running |
| done | output | 1 | One-cycle pulse that marks a new dout |
| dout | output | WORD_W | Corrected conversion word |

## Verification
The checker watches several rules on every cycle:
- done is a single-cycle pulse with busy low.
- dout holds between done pulses.
- dac_sel echoes the previous step's code.
- in_sel is 0 outside a conversion and in its first step.
- A start taken while idle raises busy.
- A counter confirms that each conversion lasts N_STEPS busy cycles.

The arithmetic of the corrected word can only be shown by the bench, which compares it with a reference sum. Its scenarios include carry chains from all-maximum codes and starts asserted in the middle of a conversion.

// File: rtl/cyc_adc_pkg.sv
package cyc_adc_pkg;

   // Bits needed for the largest corrected word: every step at full code.
   function automatic int word_width(int sb, int eb, int n);
      longint peak;
      peak = 0;
      for (int k = 0; k < n; k++)
         peak = (peak << eb) + ((longint'(1) << sb) - 1);
      return $clog2(peak + 1);
   endfunction

endpackage

// File: rtl/cyc_step_ctrl.sv
module cyc_step_ctrl #(
   parameter int N_STEPS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soc,
   output logic busy,
   output logic first,
   output logic last,
   output logic done
);
   localparam int CW = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
   localparam logic [CW-1:0] LAST_STEP = CW'(N_STEPS - 1);

   logic [CW-1:0] step;

   assign first = busy && (step == '0);
   assign last  = busy && (step == LAST_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (!busy) begin
            if (soc) begin
               busy <= 1'b1;
               step <= '0;
            end
         end else if (last) begin
            busy <= 1'b0;
            step <= '0;
         end else begin
            step <= step + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cyc_shift_acc.sv
module cyc_shift_acc #(
   parameter int SB = 3,
   parameter int EB = 2,
   parameter int W  = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic          first,
   input  logic          last,
   input  logic [SB-1:0] code,
   output logic [W-1:0]  word
);
   logic [W-1:0] acc;
   logic [W-1:0] nxt;

   generate
      if (EB == SB) begin : g_concat
         // No overlap between steps: shifting and ORing is enough.
         always_comb nxt = (acc << EB) | W'(code);
      end else begin : g_carry
         // Redundant bits overlap: a full add resolves the carries.
         always_comb nxt = (acc << EB) + W'(code);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         word <= '0;
      end else if (cap) begin
         acc <= first ? W'(code) : nxt;
         if (last)
            word <= nxt;
      end
   end
endmodule

// File: rtl/cyc_adc_seq.sv
module cyc_adc_seq #(
   parameter int SUB_BITS = 3,
   parameter int EFF_BITS = 2,
   parameter int N_STEPS  = 5,
   localparam int WORD_W  = cyc_adc_pkg::word_width(SUB_BITS, EFF_BITS, N_STEPS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soc,
   input  logic [SUB_BITS-1:0] sub_code,
   output logic                in_sel,
   output logic [SUB_BITS-1:0] dac_sel,
   output logic                busy,
   output logic                done,
   output logic [WORD_W-1:0]   dout
);
   // R9: parameter legality
   generate
      if (SUB_BITS < 1 || SUB_BITS > 6) begin : g_bad_sub
         $error("SUB_BITS must be 1..6");
      end
      if (EFF_BITS < 1 || EFF_BITS > SUB_BITS) begin : g_bad_eff
         $error("EFF_BITS must be 1..SUB_BITS");
      end
      if (N_STEPS < 2) begin : g_bad_steps
         $error("N_STEPS must be at least 2");
      end
   endgenerate

   logic first_step;
   logic last_step;

   cyc_step_ctrl #(.N_STEPS(N_STEPS)) i_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .soc   (soc),
      .busy  (busy),
      .first (first_step),
      .last  (last_step),
      .done  (done)
   );

   cyc_shift_acc #(.SB(SUB_BITS), .EB(EFF_BITS), .W(WORD_W)) i_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (busy),
      .first (first_step),
      .last  (last_step),
      .code  (sub_code),
      .word  (dout)
   );

   // R3: the residue path is selected after the first step
   assign in_sel = busy && !first_step;

   // R4: echo the captured code to the DAC
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dac_sel <= '0;
      else if (busy)
         dac_sel <= sub_code;
   end
endmodule

// File: rtl/cyc_adc_seq_chk.sv
module cyc_adc_seq_chk #(
   parameter int N_STEPS  = 5,
   parameter int SUB_BITS = 3,
   parameter int WORD_W   = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                soc,
   input logic [SUB_BITS-1:0] sub_code,
   input logic                in_sel,
   input logic [SUB_BITS-1:0] dac_sel,
   input logic                busy,
   input logic                done,
   input logic [WORD_W-1:0]   dout
);
   localparam int RW = $clog2(N_STEPS + 1) + 1;
   logic [RW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= '0;
      else        run <= busy ? run + 1'b1 : '0;
   end

   a_r2_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && soc) |=> busy);
   a_r2_length: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run == RW'(N_STEPS)));
   a_r3_first_external: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !in_sel);
   a_r3_idle_external: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !in_sel);
   a_r4_dac_echo: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> (dac_sel == $past(sub_code)));
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r8_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(dout));
endmodule

bind cyc_adc_seq cyc_adc_seq_chk #(
   .N_STEPS(N_STEPS), .SUB_BITS(SUB_BITS), .WORD_W(WORD_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .soc(soc), .sub_code(sub_code),
   .in_sel(in_sel), .dac_sel(dac_sel), .busy(busy), .done(done), .dout(dout)
);

// File: tb/test_cyc_adc_seq.sv
module test_cyc_adc_seq;
   localparam int SB = 3;
   localparam int EB = 2;
   localparam int N  = 5;
   localparam int W  = cyc_adc_pkg::word_width(SB, EB, N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soc = 1'b0;
   logic [SB-1:0] sub_code = '0;
   logic          in_sel;
   logic [SB-1:0] dac_sel;
   logic          busy;
   logic          done;
   logic [W-1:0]  dout;

   int vectors = 0;
   int errors  = 0;
   int codes [N];
   longint prev_word = 0;

   always #2.5 clk = ~clk;

   cyc_adc_seq #(.SUB_BITS(SB), .EFF_BITS(EB), .N_STEPS(N)) i_cyc_adc_seq (
      .clk(clk), .rst_n(rst_n), .soc(soc), .sub_code(sub_code),
      .in_sel(in_sel), .dac_sel(dac_sel), .busy(busy), .done(done), .dout(dout)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint ref_word();
      longint s = 0;
      for (int k = 0; k < N; k++) s = s * (longint'(1) << EB) + codes[k];
      return s;
   endfunction

   // ign < 0: no extra start; otherwise soc is raised during step ign
   task automatic run_conv(input int ign);
      longint exp = ref_word();
      soc = 1'b1;
      @(negedge clk);
      for (int k = 0; k < N; k++) begin
         sub_code = SB'(codes[k]);
         soc = (k == ign);
         chk("R2 busy during step", busy, 1);
         chk("R3 in_sel per step", in_sel, (k != 0));
         if (k > 0) chk("R4 dac_sel echo", dac_sel, codes[k-1]);
         chk("R7 no early done", done, 0);
         chk("R8 dout held", dout, prev_word);
         @(negedge clk);
      end
      soc = 1'b0;
      chk("R7 done pulse", done, 1);
      chk("R7 busy low at done", busy, 0);
      chk("R5 corrected word", dout, exp);
      chk("R4 last dac_sel", dac_sel, codes[N-1]);
      @(negedge clk);
      chk("R7 done one cycle", done, 0);
      chk("R6 no restart", busy, 0);
      chk("R8 dout stable after done", dout, exp);
      prev_word = exp;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      chk("R1 busy in reset", busy, 0);
      chk("R1 done in reset", done, 0);
      chk("R1 in_sel in reset", in_sel, 0);
      chk("R1 dac_sel in reset", dac_sel, 0);
      chk("R1 dout in reset", dout, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", busy, 0);
      chk("R1 dout after reset", dout, 0);

      // R5: all ones of each code, long carry chain
      for (int k = 0; k < N; k++) codes[k] = (1 << SB) - 1;
      run_conv(-1);
      // R5: all zero
      for (int k = 0; k < N; k++) codes[k] = 0;
      run_conv(-1);
      // R5: mixed pattern with overlapping bits
      codes[0] = 1; codes[1] = 7; codes[2] = 2; codes[3] = 5; codes[4] = 4;
      run_conv(-1);
      // R6: start asserted mid conversion and on the final step
      codes[0] = 6; codes[1] = 3; codes[2] = 0; codes[3] = 7; codes[4] = 1;
      run_conv(2);
      run_conv(N - 1);

      // R5/R6: random codes, sometimes with a stray start
      for (int r = 0; r < 40; r++) begin
         for (int k = 0; k < N; k++) codes[k] = int'($urandom % (1 << SB));
         run_conv(($urandom % 3 == 0) ? int'($urandom % N) : -1);
         repeat ($urandom % 3) @(negedge clk);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule